// File: doc/BRIEF.md
# Dual-Window Circular Sample Buffer

This block keeps the most recent `TAPS + PROJ` input samples of an adaptive filter in a register array organised as a ring. Each filter iteration may push one new sample. Pushing a sample moves a head pointer down by one and writes the sample at the new head. Nothing already stored moves. Position 0 of the logical sequence is always the newest sample, and older samples sit at higher positions.

Three read windows are laid over the same storage, and a window-select and an index choose one sample per request:

- The short window is the newest `PROJ` samples.
- The long window is the oldest `TAPS` samples of the stored sequence, starting at logical position `PROJ`.
- The delayed window is the short window as it stood `TAPS` pushes earlier. The arithmetic that follows reads it to remove old terms from a running correlation.

Reads take one cycle. A push and a read in the same cycle are resolved write-first.

Top module: `dual_window_sample_buf`

## Requirements
- R1: While `rst_n` is low, `rd_valid_o` is 0. After reset, every position of every window reads as 0 until samples are pushed over it.
- R2: A legal read request in cycle t gives `rd_valid_o` = 1 and its data in cycle t+1. With no request, `rd_valid_o` is 0 in the next cycle.
- R3: Window code 0 (short) with index i, for 0 <= i < PROJ, returns the sample pushed i pushes before the newest one. Index 0 is the newest sample.
- R4: Window code 1 (long) with index i, for 0 <= i < TAPS, returns logical position PROJ+i, which is the sample pushed PROJ+i pushes before the newest one.
- R5: Window code 2 (delayed) with index i, for 0 <= i < PROJ, returns logical position TAPS+i. This equals what the short window returned at index i exactly TAPS pushes earlier.
- R6: After more than TAPS+PROJ pushes, the oldest samples are overwritten. Reads stay correct across the ring boundary, including when TAPS+PROJ is not a power of two.
- R7: When `push_i` and a read are in the same cycle, the read sees the storage after the push. The short window at index 0 returns the sample being pushed.
- R8: Cycles without `push_i` leave the stored sequence unchanged. Repeated reads of the same window and index return the same value.
- R9: Window code 3, or an index at or beyond the selected window's length, is not a legal request. `rd_valid_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push a new sample this cycle |
| push_data_i | input | DATA_W | Sample being pushed |
| rd_req_i | input | 1 | Read request |
| rd_win_i | input | 2 | Window select: 0 short, 1 long, 2 delayed, 3 reserved |
| rd_idx_i | input | IDX_W | Index within the selected window |
| rd_valid_o | output | 1 | Read data valid, one cycle after a legal request |
| rd_data_o | output | DATA_W | Read sample |

## Verification
The bench pushes well over TAPS+PROJ samples, so the head pointer passes from 0 to its top value several times with a non-power-of-two depth. A design that wrapped modulo a power of two would return wrong or stale samples there. Pushes and reads are issued in the same cycle to catch read-first behaviour, which would return the previous newest sample at short index 0. The delayed window and the last long-window index are read at every point of history, so an offset that is off by one position shows up as a neighbour's value. Reserved codes and out-of-range indices are issued to expose a design that raises valid on them.

// File: rtl/dwsb_pkg.sv
// Package: shared types for the dual-window sample buffer.
// Assumes: window codes are fixed by the port contract (0 short, 1 long, 2 delayed).
package dwsb_pkg;
    typedef enum logic [1:0] {
        WIN_SHORT = 2'd0,
        WIN_LONG  = 2'd1,
        WIN_DELAY = 2'd2,
        WIN_RSVD  = 2'd3
    } win_e;
endpackage

// File: rtl/dwsb_head.sv
// Module: head pointer of the sample ring.
// Moves down by one on each push, wrapping from 0 to DEPTH-1, and offers the
// post-push value combinationally so that same-cycle reads see the new sample.
// Assumes: DEPTH >= 2 and ADDR_W wide enough to hold DEPTH-1.
module dwsb_head #(
    parameter int DEPTH  = 36,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    output logic [ADDR_W-1:0] head_q_o,
    output logic [ADDR_W-1:0] head_nx_o
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] head_q;

    // Next head: step down on push, wrap at zero.
    always_comb begin
        if (push_i) begin
            head_nx_o = (head_q == '0) ? TOP : head_q - 1'b1;
        end else begin
            head_nx_o = head_q;
        end
    end

    // Head register: cleared by reset, otherwise loads the next head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
        end else begin
            head_q <= head_nx_o;
        end
    end

    assign head_q_o = head_q;

    assert_head_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && head_q == '0) |=> head_q == TOP);
    assert_head_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        head_q <= TOP);
    assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !push_i |=> $stable(head_q));
endmodule

// File: rtl/dwsb_addr_map.sv
// Module: maps (window, index) to a physical slot relative to the head.
// Adds the window offset and the index to the head, folds the sum back into
// 0..DEPTH-1, and flags requests that fall outside the chosen window.
// Assumes: PROJ <= TAPS, so every legal offset+index is below DEPTH.
module dwsb_addr_map #(
    parameter int TAPS   = 32,
    parameter int PROJ   = 4,
    parameter int DEPTH  = 36,
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 5
) (
    input  logic [ADDR_W-1:0] head_i,
    input  dwsb_pkg::win_e    win_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              legal_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int SUM_W = ADDR_W + 1;
    localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0);

    logic [SUM_W-1:0] win_off;
    logic [SUM_W-1:0] win_len;
    logic [SUM_W-1:0] raw_sum;

    // Window table: start offset and length per window code.
    always_comb begin
        unique case (win_i)
            dwsb_pkg::WIN_SHORT: begin win_off = '0;            win_len = SUM_W'(PROJ); end
            dwsb_pkg::WIN_LONG:  begin win_off = SUM_W'(PROJ);  win_len = SUM_W'(TAPS); end
            dwsb_pkg::WIN_DELAY: begin win_off = SUM_W'(TAPS);  win_len = SUM_W'(PROJ); end
            default:             begin win_off = '0;            win_len = '0;           end
        endcase
    end

    // Legality and unwrapped position relative to the head.
    always_comb begin
        legal_o = (SUM_W'(idx_i) < win_len);
        raw_sum = SUM_W'(head_i) + win_off + SUM_W'(idx_i);
    end

    // Fold into the ring: a mask for power-of-two depth, a subtract otherwise.
    generate
        if (POW2) begin : g_fold_mask
            assign addr_o = raw_sum[ADDR_W-1:0];
        end else begin : g_fold_sub
            logic [SUM_W-1:0] folded;
            always_comb begin
                folded = (raw_sum >= SUM_W'(DEPTH)) ? raw_sum - SUM_W'(DEPTH) : raw_sum;
            end
            assign addr_o = folded[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/dwsb_store.sv
// Module: sample storage, one write port and one registered read port.
// Reset clears every slot, which models zero history before time 0.
// A read of the slot written in the same cycle returns the new data.
// Assumes: addresses are already below DEPTH.
module dwsb_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 36,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Array write and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                mem[s] <= '0;
            end
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // Registered read with write-first forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (we_i && (waddr_i == raddr_i)) begin
            rdata_o <= wdata_i;
        end else begin
            rdata_o <= mem[raddr_i];
        end
    end
endmodule

// File: rtl/dual_window_sample_buf.sv
// Module: dual-window circular sample buffer (top).
// Holds the newest TAPS+PROJ samples in a ring addressed by a moving head and
// serves short, long and delayed windows with one-cycle read latency.
// Assumes: 2 <= PROJ <= TAPS; one push at most per cycle.
module dual_window_sample_buf #(
    parameter int DATA_W = 16,
    parameter int TAPS   = 32,
    parameter int PROJ   = 4,
    parameter int DEPTH  = TAPS + PROJ,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int IDX_W  = $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              rd_req_i,
    input  logic [1:0]        rd_win_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [ADDR_W-1:0] head_q;
    logic [ADDR_W-1:0] head_nx;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_legal;
    logic              rd_ok;
    logic              valid_q;
    dwsb_pkg::win_e    win_sel;

    assign win_sel = dwsb_pkg::win_e'(rd_win_i);
    assign rd_ok   = rd_req_i && rd_legal;

    dwsb_head #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .head_q_o (head_q),
        .head_nx_o(head_nx)
    );

    dwsb_addr_map #(
        .TAPS(TAPS), .PROJ(PROJ), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_map (
        .head_i (head_nx),
        .win_i  (win_sel),
        .idx_i  (rd_idx_i),
        .legal_o(rd_legal),
        .addr_o (rd_addr)
    );

    dwsb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (push_i),
        .waddr_i(head_nx),
        .wdata_i(push_data_i),
        .raddr_i(rd_addr),
        .rdata_o(rd_data_o)
    );

    // Valid flag aligned with the registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_ok;
        end
    end

    assign rd_valid_o = valid_q;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !rd_valid_o);
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> rd_valid_o);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_i |=> !rd_valid_o);
    assert_illegal_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && !rd_legal) |=> !rd_valid_o);
    assert_slot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> rd_addr < ADDR_W'(DEPTH));
    assert_write_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && rd_req_i && rd_win_i == 2'd0 && rd_idx_i == '0)
        |=> rd_data_o == $past(push_data_i));
endmodule

// File: tb/dual_window_sample_buf_bench.sv
module dual_window_sample_buf_bench;
    localparam int DATA_W = 16;
    localparam int TAPS   = 32;
    localparam int PROJ   = 4;
    localparam int DEPTH  = TAPS + PROJ;
    localparam int IDX_W  = $clog2(TAPS);

    typedef struct {
        bit              v;
        logic [DATA_W-1:0] d;
        string           tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0;
    logic [DATA_W-1:0] push_data_i = '0;
    logic              rd_req_i = 1'b0;
    logic [1:0]        rd_win_i = 2'd0;
    logic [IDX_W-1:0]  rd_idx_i = '0;
    logic              rd_valid_o;
    logic [DATA_W-1:0] rd_data_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    exp_t              q[$];
    logic [DATA_W-1:0] hist[$];

    always #5 clk = ~clk;

    dual_window_sample_buf #(.DATA_W(DATA_W), .TAPS(TAPS), .PROJ(PROJ)) u_dual_window_sample_buf (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .rd_req_i(rd_req_i), .rd_win_i(rd_win_i), .rd_idx_i(rd_idx_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    function automatic logic [DATA_W-1:0] model_at(int pos);
        return (pos < hist.size()) ? hist[pos] : '0;
    endfunction

    // Driver: one cycle of stimulus, expected result queued for the monitor.
    task automatic cyc(bit p, logic [DATA_W-1:0] d, bit r, int w, int i, string tag);
        exp_t e;
        int off;
        int len;
        @(negedge clk);
        push_i = p; push_data_i = d; rd_req_i = r;
        rd_win_i = 2'(w); rd_idx_i = IDX_W'(i);
        if (p) begin
            hist.push_front(d);
            if (hist.size() > DEPTH) void'(hist.pop_back());
        end
        off = (w == 1) ? PROJ : (w == 2) ? TAPS : 0;
        len = (w == 0) ? PROJ : (w == 1) ? TAPS : (w == 2) ? PROJ : 0;
        e.v = r && (i < len);
        e.d = e.v ? model_at(off + i) : '0;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        cyc(0, '0, 0, 0, 0, "R2");
    endtask

    // Monitor: compares each cycle's output after the edge settles.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (rst_n && q.size() > 0) begin
            e = q.pop_front();
            n_checks++;
            if (rd_valid_o !== e.v) begin
                n_fails++;
                $display("FAIL %s: valid actual %0b expected %0b", e.tag, rd_valid_o, e.v);
            end else if (e.v && rd_data_o !== e.d) begin
                n_fails++;
                $display("FAIL %s: data actual %h expected %h", e.tag, rd_data_o, e.d);
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: valid stays low during reset
        repeat (3) begin
            @(negedge clk);
            n_checks++;
            if (rd_valid_o !== 1'b0) begin
                n_fails++;
                $display("FAIL R1: valid in reset actual %b expected 0", rd_valid_o);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: everything reads as zero after reset
        for (int i = 0; i < TAPS; i++) cyc(0, '0, 1, 1, i, "R1");
        for (int i = 0; i < PROJ; i++) cyc(0, '0, 1, 0, i, "R1");
        for (int i = 0; i < PROJ; i++) cyc(0, '0, 1, 2, i, "R1");
        idle();
        // R3/R4: a few pushes, then read both windows
        for (int s = 1; s <= 6; s++) cyc(1, DATA_W'(16'h1000 + s), 0, 0, 0, "R2");
        for (int i = 0; i < PROJ; i++) cyc(0, '0, 1, 0, i, "R3");
        for (int i = 0; i < TAPS; i++) cyc(0, '0, 1, 1, i, "R4");
        // R8: no pushes, repeated reads are stable
        for (int i = 0; i < PROJ; i++) cyc(0, '0, 1, 0, i, "R8");
        cyc(0, '0, 1, 1, TAPS - 1, "R8");
        cyc(0, '0, 1, 1, TAPS - 1, "R8");
        // R6/R5: many pushes past the ring size, reads spread over all windows
        for (int s = 0; s < 5 * DEPTH; s++) begin
            cyc(1, DATA_W'(s * 37 + 11), 0, 0, 0, "R6");
            cyc(0, '0, 1, 1, (s * 7) % TAPS, "R6");
            cyc(0, '0, 1, 2, s % PROJ, "R5");
            cyc(0, '0, 1, 0, (s * 3) % PROJ, "R3");
        end
        for (int i = 0; i < PROJ; i++) cyc(0, '0, 1, 2, i, "R5");
        cyc(0, '0, 1, 1, TAPS - 1, "R6");
        // R7: push and read in the same cycle
        for (int s = 0; s < 2 * DEPTH; s++) begin
            cyc(1, DATA_W'(16'hA000 + s * 5), 1, 0, 0, "R7");
            cyc(1, DATA_W'(16'hB000 + s), 1, s % 3, s % PROJ, "R7");
        end
        // R9: reserved code and out-of-range indices
        cyc(0, '0, 1, 3, 0, "R9");
        cyc(0, '0, 1, 0, PROJ, "R9");
        cyc(0, '0, 1, 2, TAPS - 1, "R9");
        cyc(1, 16'h5A5A, 1, 3, 1, "R9");
        cyc(0, '0, 1, 0, 0, "R9");
        idle();
        idle();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule